// File: doc/BRIEF.md
# DMA request input sampler

This block conditions the external request pins of a multi-channel DMA controller before they reach the channel arbiter. Each pin first passes through a two-flop synchronizer. After that, a per-channel sense selector decides how the synchronized pin turns into a request: as an active-low level, an active-high level, a falling edge or a rising edge. Level requests follow the pin on every cycle. Edge requests are latched as pending and stay pending until the channel acknowledges them.

Only the first `NPIN` channels have a pin and a sense selector. The other channels read back zero, discard writes and never raise a pin request. On a channel that has a pin, the pin is used only while the channel's request source is set to external. While the channel uses an internal peripheral source or auto-request, the pin and the sense setting have no effect on that channel.

Top module: `dreq_sampler`

## Requirements
- R1: After a synchronous reset, every sense selector reads 00 and no edge request is pending.
- R2: Selector 00 (active-low level) drives `req_out` high while the synchronized pin is low. The output follows the pin two clock edges after the pin changes and needs no acknowledge.
- R3: Selector 10 (active-high level) drives `req_out` high while the synchronized pin is high, with the same two-edge latency.
- R4: Selector 01 (falling edge) latches a pending request when the synchronized pin goes high to low. `req_out` rises three clock edges after the pin falls and stays high whatever the pin does afterwards.
- R5: Selector 11 (rising edge) latches a pending request when the synchronized pin goes low to high, with the same three-edge latency.
- R6: An `ack` for a channel clears that channel's pending edge request at the next edge. If a new edge is detected in the same cycle as the `ack`, the request stays pending.
- R7: While `src_ext` for a channel is 0, that channel's `req_out` is 0, no edge is latched, and any pending request is dropped.
- R8: Channels at index `NPIN` and above read selector 00, ignore writes and keep `req_out` at 0.
- R9: A write to a channel's selector clears that channel's pending edge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Selector write strobe |
| cfg_wr_ch | input | 2 | Channel addressed by the write |
| cfg_wdata | input | 2 | Selector value: bit1 = active high/rising, bit0 = edge mode |
| cfg_rd_ch | input | 2 | Channel addressed by the read |
| cfg_rdata | output | 2 | Selector of the read channel (00 on channels without a pin) |
| pin_raw | input | 2 | Asynchronous request pins, one per pin channel |
| src_ext | input | 4 | Per channel: 1 selects the external pin as request source |
| ack | input | 4 | Per channel acknowledge for a pending edge request |
| req_out | output | 4 | Per channel request to the arbiter |

## Verification
The bench drives a falling edge and a new edge in the same cycle as `ack`. A design that lets `ack` win here would lose a request. It also rewrites the selector while a request is pending. A design that does not clear on a write would start a transfer under the wrong sense mode. Writes to the channels without a pin are tried as well: a design that keeps those bits would read back nonzero. The bench also switches `src_ext` off with an edge pending. A design that keeps the latch through this would fire a stale request when the source returns to external. Random stimulus covers all four sense modes, so a swapped polarity or an off-by-one synchronizer latency shows up as a `req_out` mismatch.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    // Sense selector encoding: bit1 = active high/rising, bit0 = edge mode
    typedef enum logic [1:0] {
        SNS_LOW_LVL  = 2'b00,
        SNS_FALL     = 2'b01,
        SNS_HIGH_LVL = 2'b10,
        SNS_RISE     = 2'b11
    } sense_e;

    typedef struct packed {
        logic active_high;
        logic edge_mode;
    } sense_t;

    function automatic sense_t sense_decode(input sense_e s);
        sense_t d;
        d.active_high = s[1];
        d.edge_mode   = s[0];
        return d;
    endfunction

    // Pin is at its asserted value for this selector
    function automatic logic pin_active(input sense_t d, input logic lvl);
        return lvl == d.active_high;
    endfunction

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int   WIDTH   = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= {WIDTH{RST_VAL}};
            q_sync <= {WIDTH{RST_VAL}};
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/dreq_chan.sv
module dreq_chan
    import dreq_pkg::*;
#(
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  sense_e wr_sel,
    input  logic   pin_s,
    input  logic   src_ext,
    input  logic   ack,
    output sense_e sel_q,
    output logic   req
);
    sense_t dec;
    logic   prev_q;
    logic   pend_q;
    logic   edge_hit;

    assign dec = sense_decode(sel_q);

    // Edge: synchronized pin now asserted, previous sample was not
    assign edge_hit = dec.edge_mode && src_ext
                      && pin_active(dec, pin_s) && !pin_active(dec, prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= SNS_LOW_LVL;
            prev_q <= IDLE_VAL;
            pend_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
            if (wr_en) sel_q <= wr_sel;
            if (wr_en || !src_ext)  pend_q <= 1'b0;
            else if (edge_hit)      pend_q <= 1'b1;
            else if (ack)           pend_q <= 1'b0;
        end
    end

    always_comb begin
        if (!src_ext)           req = 1'b0;
        else if (dec.edge_mode) req = pend_q;
        else                    req = pin_active(dec, pin_s);
    end

    AST_RESET_CLEAN: assert property (@(posedge clk) rst |=> (sel_q == SNS_LOW_LVL) && !pend_q); // R1
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !ack && src_ext && !wr_en) |=> pend_q); // R4
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ack && !edge_hit) |=> !pend_q); // R6
    AST_SRC_DROP: assert property (@(posedge clk) disable iff (rst)
        !src_ext |=> !pend_q); // R7
    AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !pend_q); // R9
endmodule

// File: rtl/dreq_sampler.sv
module dreq_sampler
    import dreq_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NPIN = 2,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic [CHW-1:0]  cfg_wr_ch,
    input  logic [1:0]      cfg_wdata,
    input  logic [CHW-1:0]  cfg_rd_ch,
    output logic [1:0]      cfg_rdata,
    input  logic [NPIN-1:0] pin_raw,
    input  logic [NCH-1:0]  src_ext,
    input  logic [NCH-1:0]  ack,
    output logic [NCH-1:0]  req_out
);
    logic [NPIN-1:0] pin_s;
    sense_e          sel_arr [NCH];

    dreq_sync #(.WIDTH(NPIN), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pin_raw),
        .q_sync  (pin_s)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        if (c < NPIN) begin : g_pin
            logic wr_hit;
            assign wr_hit = cfg_we && (cfg_wr_ch == CHW'(c));
            dreq_chan #(.IDLE_VAL(1'b1)) u_chan (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (wr_hit),
                .wr_sel  (sense_e'(cfg_wdata)),
                .pin_s   (pin_s[c]),
                .src_ext (src_ext[c]),
                .ack     (ack[c]),
                .sel_q   (sel_arr[c]),
                .req     (req_out[c])
            );
        end else begin : g_nopin
            assign sel_arr[c] = SNS_LOW_LVL;
            assign req_out[c] = 1'b0;
        end
    end

    assign cfg_rdata = sel_arr[cfg_rd_ch];

    AST_NOPIN_READ: assert property (@(posedge clk) disable iff (rst)
        (int'(cfg_rd_ch) >= NPIN) |-> (cfg_rdata == 2'b00)); // R8
endmodule

// File: tb/dreq_sampler_tb.sv
module dreq_sampler_tb;
    localparam int NCH = 4, NPIN = 2;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_wr_ch = '0, cfg_wdata = '0, cfg_rd_ch = '0, cfg_rdata;
    logic [NPIN-1:0] pin_raw = '1;
    logic [NCH-1:0] src_ext = '0, ack = '0, req_out;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic m_s1 [NPIN], m_s2 [NPIN], m_prev [NPIN], m_pend [NPIN];
    logic [1:0] m_sel [NPIN];

    always #10 clk = ~clk;

    dreq_sampler #(.NCH(NCH), .NPIN(NPIN)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wr_ch(cfg_wr_ch),
        .cfg_wdata(cfg_wdata), .cfg_rd_ch(cfg_rd_ch), .cfg_rdata(cfg_rdata),
        .pin_raw(pin_raw), .src_ext(src_ext), .ack(ack), .req_out(req_out)
    );

    // Reference model from the requirements, updated on each clock edge
    task automatic model_edge();
        for (int c = 0; c < NPIN; c++) begin
            if (rst) begin
                m_s1[c] = 1; m_s2[c] = 1; m_prev[c] = 1; m_pend[c] = 0; m_sel[c] = 2'b00;
            end else begin
                logic det;
                det = m_sel[c][0] && src_ext[c] && (m_s2[c] == m_sel[c][1])
                      && (m_prev[c] != m_sel[c][1]);
                if ((cfg_we && cfg_wr_ch == 2'(c)) || !src_ext[c]) m_pend[c] = 0;
                else if (det) m_pend[c] = 1;
                else if (ack[c]) m_pend[c] = 0;
                if (cfg_we && cfg_wr_ch == 2'(c)) m_sel[c] = cfg_wdata;
                m_prev[c] = m_s2[c];
                m_s2[c] = m_s1[c];
                m_s1[c] = pin_raw[c];
            end
        end
    endtask

    function automatic logic [NCH-1:0] exp_req();
        logic [NCH-1:0] r = '0;
        for (int c = 0; c < NPIN; c++)
            if (src_ext[c]) r[c] = m_sel[c][0] ? m_pend[c] : (m_s2[c] == m_sel[c][1]);
        return r;
    endfunction

    function automatic logic [1:0] exp_rd();
        return (int'(cfg_rd_ch) < NPIN) ? m_sel[cfg_rd_ch] : 2'b00;
    endfunction

    function automatic string mode_tag(int c);
        case (m_sel[c])
            2'b00: return "R2";
            2'b10: return "R3";
            2'b01: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag);
        n_run++;
        if (req_out !== exp_req() || cfg_rdata !== exp_rd()) begin
            n_fail++;
            $display("FAIL %s: req_out=%b rdata=%b expected req_out=%b rdata=%b",
                     tag, req_out, cfg_rdata, exp_req(), exp_rd());
        end
    endtask

    task automatic step(string tag);
        @(posedge clk); model_edge();
        @(negedge clk); check(tag);
    endtask

    task automatic wr(int ch, logic [1:0] v, string tag);
        cfg_we = 1; cfg_wr_ch = 2'(ch); cfg_wdata = v; cfg_rd_ch = 2'(ch);
        step(tag);
        cfg_we = 0;
    endtask

    initial begin
        #(20ns * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < 3; i++) begin @(posedge clk); model_edge(); end
        @(negedge clk); rst = 0;
        for (int c = 0; c < NCH; c++) begin cfg_rd_ch = 2'(c); #1; check("R1"); end

        // R2: active-low level on channel 0
        src_ext = 4'b0001; cfg_rd_ch = 0;
        step("R2"); pin_raw[0] = 0; step("R2"); step("R2"); pin_raw[0] = 1; step("R2"); step("R2");
        // R3: active-high level
        wr(0, 2'b10, "R3"); step("R3"); pin_raw[0] = 0; step("R3"); step("R3");
        // R4: falling edge latched, holds after pin returns high
        wr(0, 2'b01, "R4"); pin_raw[0] = 0; step("R4"); step("R4"); step("R4");
        pin_raw[0] = 1; for (int i = 0; i < 4; i++) step("R4");
        // R6: ack alone clears
        ack[0] = 1; step("R6"); ack[0] = 0; step("R6");
        // R6: new edge in same cycle as ack keeps pending
        pin_raw[0] = 0; step("R6"); step("R4");  // edge detect now live
        pin_raw[0] = 1; step("R4");              // pending set
        for (int i = 0; i < 3; i++) step("R4");
        pin_raw[0] = 0; step("R6"); step("R6");  // detect combinational in next cycle
        ack[0] = 1; step("R6"); ack[0] = 0; step("R6");
        // R9: write clears pending
        ack[0] = 1; step("R6"); ack[0] = 0;
        wr(0, 2'b11, "R5"); pin_raw[0] = 1; step("R5"); step("R5"); step("R5");
        wr(0, 2'b11, "R9"); step("R9");
        // R7: source off ignores pin and drops pending
        pin_raw[0] = 0; step("R7"); step("R7"); pin_raw[0] = 1; step("R7"); step("R7"); step("R7");
        src_ext[0] = 0; step("R7"); src_ext[0] = 1; step("R7"); step("R7");
        src_ext = 4'b0000; wr(1, 2'b10, "R7"); pin_raw[1] = 1; step("R7"); step("R7");
        // R8: channels without a pin
        src_ext = 4'b1111;
        wr(2, 2'b11, "R8"); wr(3, 2'b10, "R8");
        cfg_rd_ch = 2; #1; check("R8"); cfg_rd_ch = 3; #1; check("R8");

        // Constrained random phase
        for (int i = 0; i < 3000; i++) begin
            int c;
            c = $urandom_range(0, NPIN - 1);
            pin_raw = NPIN'($urandom);
            ack = ($urandom_range(0, 3) == 0) ? NCH'($urandom) : '0;
            if ($urandom_range(0, 15) == 0) src_ext = NCH'($urandom);
            cfg_rd_ch = 2'($urandom);
            if ($urandom_range(0, 20) == 0) begin
                cfg_we = 1; cfg_wr_ch = 2'($urandom); cfg_wdata = 2'($urandom);
            end
            step(mode_tag(c));
            cfg_we = 0;
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule